// File: doc/BRIEF.md
# Dual-Capture 16-bit Timer/Event Counter

This block is a 16-bit up counter with two compare registers and two capture registers. The count advances on one of three prescaler tick inputs or on rising edges of an external input. It can run freely and wrap, or it can clear itself after reaching the second compare value, which makes it an interval timer. When the counter reaches a compare value, the block raises a one-cycle interrupt strobe. The first compare register can be double-buffered, so that a new value takes effect only at the next counter restart.

A capture unit watches the synchronised external trigger. It latches the counter into the two capture registers under one of four timing modes. This supports pulse-width, period and time-difference measurement. Software can also take a snapshot of the count into the first capture register at any time.

An output flip-flop drives the timer pin. Four event sources can invert it: each compare match and each capture load, and each source has its own enable. Software can also force the flip-flop to a chosen level. Together these produce PPG waveforms of either polarity, and delayed one-shot pulses that follow an external trigger.

Top module: `dcap_timer16`

## Requirements
- R1: After reset the counter, both compare registers, both capture registers, the control register, `tmr_out`, `irq_cmpa` and `irq_cmpb` are all zero.
- R2: While control bit 0 (run) is 0, the counter holds at zero. While run is 1, the counter advances by one on each cycle in which the selected tick is high. Control bits 2:1 select the tick: 0 selects `tap_tick[0]`, 1 selects `tap_tick[1]`, 2 selects `tap_tick[2]`, and 3 selects the external count source.
- R3: With control bit 5 (auto-clear) set, the counter moves from the compare B value to 0 on the next tick, so the period is compare B + 1 ticks. With auto-clear clear, the counter wraps from 0xFFFF to 0.
- R4: `irq_cmpa` and `irq_cmpb` each pulse high for one cycle, in the same cycle as the counter register first shows the compare A or compare B value after a tick.
- R5: With control bit 6 (double buffer) set, a write to compare A (address 1) is held in a buffer. It becomes active on the tick that restarts the counter, which is the auto-clear or the wrap. With the bit clear, a write takes effect at once. Reading address 1 returns the active value.
- R6: Capture mode 01 (control bits 4:3) loads capture A (address 3) with the count on a rising edge of the trigger, and loads capture B (address 4) with the count on a falling edge.
- R7: Capture mode 10 loads capture A on every rising edge of the trigger and leaves capture B unchanged.
- R8: Capture mode 11 loads capture A on a rising edge of the trigger, and loads capture B with the compare A value whenever a compare A match occurs.
- R9: Capture mode 00 ignores trigger edges. Neither capture register changes, except capture A through the software command.
- R10: Writing the control register with bit 7 set loads capture A with the count value present just before that write's clock edge. Bit 7 reads back as 0.
- R11: Control bits 8 to 11 enable inversion of `tmr_out` by, in that order, a compare A match, a compare B match, a capture A load and a capture B load. Enabled events that occur in the same cycle each invert the output, so an even number of them leaves it unchanged.
- R12: Writing the control register with bit 12 set forces `tmr_out` to the value of bit 13, and this takes priority over any inversion. Bits 12 and 13 read back as 0.
- R13: The external count source counts rising edges of `trig_in`, taken after a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_tick | input | 3 | Prescaler tick strobes for the three internal count rates |
| trig_in | input | 1 | External trigger and event-count input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 compare A, 2 compare B, 3 capture A, 4 capture B, 5 count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| tmr_out | output | 1 | Output flip-flop |
| irq_cmpa | output | 1 | Compare A match strobe |
| irq_cmpb | output | 1 | Compare B match strobe |

## Verification
A wrong match decode or a wrong counter step shows on the strobes within one counter period. The interrupt then comes at the wrong count, and the measured spacing between compare B strobes departs from (compare B + 1) times the tick spacing. A compare A buffer that shifts at the wrong moment shows on the read-back of address 1, which changes before the restart instead of after it. Capture faults show as a wrong difference between two captured values, and the synchroniser latency cancels out of that difference. Inversion faults show in the high and low widths of `tmr_out` in the first PPG period.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

   localparam int TAP_N  = 3;
   localparam int ADDR_W = 3;
   localparam int CTRL_W = 14;
   localparam int EV_N   = 4;

   localparam int EV_CMPA = 0;
   localparam int EV_CMPB = 1;
   localparam int EV_CAPA = 2;
   localparam int EV_CAPB = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CMPB  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CAPA  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CAPB  = 3'd4;
   localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

   typedef enum logic [1:0] {
      SRC_FAST = 2'd0,
      SRC_MID  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_EXT  = 2'd3
   } clk_src_e;

   typedef enum logic [1:0] {
      CAP_OFF   = 2'd0,
      CAP_EDGES = 2'd1,
      CAP_RISE  = 2'd2,
      CAP_MATCH = 2'd3
   } cap_mode_e;

   typedef struct packed {
      logic            ff_val;
      logic            ff_ld;
      logic [EV_N-1:0] inv;
      logic            swcap;
      logic            dbuf;
      logic            autoclr;
      cap_mode_e       capm;
      clk_src_e        src;
      logic            run;
   } ctrl_t;

endpackage

// File: rtl/dcap_tick_sel.sv
module dcap_tick_sel
   import dcap_pkg::*;
#(
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAP_N-1:0] tap_tick,
   input  logic             trig_in,
   input  clk_src_e         src,
   output logic             tick,
   output logic             trig_rise,
   output logic             trig_fall
);

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("dcap_tick_sel: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N:0] sh;

   generate
      for (genvar i = 0; i <= SYNC_N; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= trig_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
            end
         end
      end
   endgenerate

   logic lvl, prv;
   assign lvl       = sh[SYNC_N-1];
   assign prv       = sh[SYNC_N];
   assign trig_rise = lvl & ~prv;
   assign trig_fall = ~lvl & prv;

   always_comb begin
      unique case (src)
         SRC_FAST: tick = tap_tick[0];
         SRC_MID:  tick = tap_tick[1];
         SRC_SLOW: tick = tap_tick[2];
         default:  tick = trig_rise;
      endcase
   end

endmodule

// File: rtl/dcap_counter.sv
module dcap_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         autoclr,
   input  logic         dbuf,
   input  logic         cmpa_wr,
   input  logic         cmpb_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cmpa_act,
   output logic [W-1:0] cmpb,
   output logic         hit_a,
   output logic         hit_b,
   output logic         reload,
   output logic         irq_a,
   output logic         irq_b
);

   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] TOP  = {W{1'b1}};

   logic [W-1:0] cmpa_buf;
   logic [W-1:0] cnt_nx;
   logic         step, at_b, at_top;

   assign step   = run & tick;
   assign at_b   = (cnt == cmpb);
   assign at_top = autoclr ? at_b : (cnt == TOP);
   assign cnt_nx = (autoclr && at_b) ? '0 : cnt + ONE;
   assign hit_a  = step & (cnt_nx == cmpa_act);
   assign hit_b  = step & (cnt_nx == cmpb);
   assign reload = step & at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         irq_a <= hit_a;
         irq_b <= hit_b;
         if (!run)      cnt <= '0;
         else if (step) cnt <= cnt_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmpa_buf <= '0;
         cmpa_act <= '0;
         cmpb     <= '0;
      end else begin
         if (cmpb_wr) cmpb <= wdata;
         if (cmpa_wr) cmpa_buf <= wdata;
         if (cmpa_wr && !dbuf)       cmpa_act <= wdata;
         else if (dbuf && reload)    cmpa_act <= cmpa_buf;
      end
   end

endmodule

// File: rtl/dcap_capture.sv
module dcap_capture
   import dcap_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cap_mode_e    capm,
   input  logic         rise,
   input  logic         fall,
   input  logic         sw_cap,
   input  logic         hit_a,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] match_val,
   output logic [W-1:0] capa,
   output logic [W-1:0] capb,
   output logic         lda,
   output logic         ldb
);

   logic rise_ld, fall_ld, match_ld;

   assign rise_ld  = rise & (capm != CAP_OFF);
   assign fall_ld  = fall & (capm == CAP_EDGES);
   assign match_ld = hit_a & (capm == CAP_MATCH);
   assign lda      = sw_cap | rise_ld;
   assign ldb      = fall_ld | match_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         capa <= '0;
         capb <= '0;
      end else begin
         if (lda)           capa <= cnt;
         if (match_ld)      capb <= match_val;
         else if (fall_ld)  capb <= cnt;
      end
   end

endmodule

// File: rtl/dcap_outff.sv
module dcap_outff #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] en,
   input  logic         ld,
   input  logic         ld_val,
   output logic         q
);

   logic [N-1:0] act;
   logic         flip;

   generate
      for (genvar i = 0; i < N; i++) begin : g_src
         assign act[i] = ev[i] & en[i];
      end
   endgenerate

   assign flip = ^act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (ld)   q <= ld_val;
      else if (flip) q <= ~q;
   end

endmodule

// File: rtl/dcap_timer16.sv
module dcap_timer16
   import dcap_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAP_N-1:0]  tap_tick,
   input  logic              trig_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              tmr_out,
   output logic              irq_cmpa,
   output logic              irq_cmpb
);

   generate
      if (CNT_W < 16 || CNT_W > 32) begin : g_bad_width
         $error("dcap_timer16: CNT_W must lie in 16..32");
      end
   endgenerate

   localparam int PAD_W = CNT_W - CTRL_W;

   ctrl_t ctrl_q, wr_ctrl, ctrl_keep;
   logic  ctrl_wr, cmpa_wr, cmpb_wr;
   logic  sw_cap, ff_ld, ff_val;

   assign wr_ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign cmpa_wr = reg_wr && (reg_addr == A_CMPA);
   assign cmpb_wr = reg_wr && (reg_addr == A_CMPB);
   assign sw_cap  = ctrl_wr & wr_ctrl.swcap;
   assign ff_ld   = ctrl_wr & wr_ctrl.ff_ld;
   assign ff_val  = wr_ctrl.ff_val;

   always_comb begin
      ctrl_keep        = wr_ctrl;
      ctrl_keep.swcap  = 1'b0;
      ctrl_keep.ff_ld  = 1'b0;
      ctrl_keep.ff_val = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_keep;
   end

   logic run_w, dbuf_w, cap_off_w;
   assign run_w     = ctrl_q.run;
   assign dbuf_w    = ctrl_q.dbuf;
   assign cap_off_w = (ctrl_q.capm == CAP_OFF);

   logic tick, trig_rise, trig_fall;

   dcap_tick_sel #(.SYNC_N(SYNC_N)) tick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_tick  (tap_tick),
      .trig_in   (trig_in),
      .src       (ctrl_q.src),
      .tick      (tick),
      .trig_rise (trig_rise),
      .trig_fall (trig_fall)
   );

   logic [CNT_W-1:0] cnt, cmpa_act, cmpb, capa, capb;
   logic             hit_a, hit_b, reload, capa_ld, capb_ld;

   dcap_counter #(.W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w),
      .tick     (tick),
      .autoclr  (ctrl_q.autoclr),
      .dbuf     (dbuf_w),
      .cmpa_wr  (cmpa_wr),
      .cmpb_wr  (cmpb_wr),
      .wdata    (reg_wdata),
      .cnt      (cnt),
      .cmpa_act (cmpa_act),
      .cmpb     (cmpb),
      .hit_a    (hit_a),
      .hit_b    (hit_b),
      .reload   (reload),
      .irq_a    (irq_cmpa),
      .irq_b    (irq_cmpb)
   );

   dcap_capture #(.W(CNT_W)) cap_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .capm      (ctrl_q.capm),
      .rise      (trig_rise),
      .fall      (trig_fall),
      .sw_cap    (sw_cap),
      .hit_a     (hit_a),
      .cnt       (cnt),
      .match_val (cmpa_act),
      .capa      (capa),
      .capb      (capb),
      .lda       (capa_ld),
      .ldb       (capb_ld)
   );

   logic [EV_N-1:0] ev;
   logic            inv_any;

   assign ev[EV_CMPA] = hit_a;
   assign ev[EV_CMPB] = hit_b;
   assign ev[EV_CAPA] = capa_ld;
   assign ev[EV_CAPB] = capb_ld;
   assign inv_any     = |(ev & ctrl_q.inv);

   dcap_outff #(.N(EV_N)) ff_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .en     (ctrl_q.inv),
      .ld     (ff_ld),
      .ld_val (ff_val),
      .q      (tmr_out)
   );

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
         A_CMPA:  reg_rdata = cmpa_act;
         A_CMPB:  reg_rdata = cmpb;
         A_CAPA:  reg_rdata = capa;
         A_CAPB:  reg_rdata = capb;
         A_COUNT: reg_rdata = cnt;
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dcap_timer16_chk.sv
module dcap_timer16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             ctrl_wr,
   input logic             cmpb_wr,
   input logic             irq_b,
   input logic             cap_off,
   input logic             sw_cap,
   input logic             dbuf,
   input logic             reload,
   input logic             ff_ld,
   input logic             inv_any,
   input logic             tmr_out,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmpb,
   input logic [CNT_W-1:0] capa,
   input logic [CNT_W-1:0] capb,
   input logic [CNT_W-1:0] cmpa_act
);

   AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));                                           // R2

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && !ctrl_wr) |=> $stable(cnt));                    // R2

   AST_STROBE_AT_CMPB: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_b && !$past(cmpb_wr)) |-> (cnt == cmpb));                   // R4

   AST_BUFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dbuf && !reload) |=> $stable(cmpa_act));                        // R5

   AST_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_off && !sw_cap) |=> ($stable(capa) && $stable(capb)));      // R9

   AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ff_ld && !inv_any) |=> $stable(tmr_out));                      // R11

endmodule

bind dcap_timer16 dcap_timer16_chk #(.CNT_W(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run_w),
   .tick     (tick),
   .ctrl_wr  (ctrl_wr),
   .cmpb_wr  (cmpb_wr),
   .irq_b    (irq_cmpb),
   .cap_off  (cap_off_w),
   .sw_cap   (sw_cap),
   .dbuf     (dbuf_w),
   .reload   (reload),
   .ff_ld    (ff_ld),
   .inv_any  (inv_any),
   .tmr_out  (tmr_out),
   .cnt      (cnt),
   .cmpb     (cmpb),
   .capa     (capa),
   .capb     (capb),
   .cmpa_act (cmpa_act)
);

// File: tb/dcap_timer16_tb_top.sv
module dcap_timer16_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  tap_tick;
   logic        trig_in = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        tmr_out, irq_cmpa, irq_cmpb;

   logic [3:0]  pcnt = 4'd0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;
   always @(negedge clk) pcnt <= pcnt + 4'd1;
   assign tap_tick = {pcnt == 4'd0, pcnt[1:0] == 2'd0, 1'b1};

   dcap_timer16 dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_tick  (tap_tick),
      .trig_in   (trig_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tmr_out   (tmr_out),
      .irq_cmpa  (irq_cmpa),
      .irq_cmpb  (irq_cmpb)
   );

   localparam logic [2:0] RC = 3'd0, RA = 3'd1, RB = 3'd2,
                          PA = 3'd3, PB = 3'd4, CN = 3'd5;

   // compare B value, tick source, expected clocks between compare B strobes
   localparam int VTAB [4][3] = '{'{9, 0, 10}, '{4, 1, 20}, '{2, 2, 48}, '{0, 0, 1}};

   function automatic logic [15:0] mk(input logic run, input logic [1:0] src,
                                      input logic [1:0] capm, input logic aclr,
                                      input logic dbuf, input logic sw,
                                      input logic [3:0] inv, input logic ffld,
                                      input logic ffval);
      return {2'b00, ffval, ffld, inv, sw, dbuf, aclr, capm, src, run};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input int hi);
      trig_in = 1'b1;
      repeat (hi) @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic measure(output int per);
      int g = 0;
      while (irq_cmpb !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
      per = 0;
      do begin @(negedge clk); per++; end while (irq_cmpb !== 1'b1 && per < 3000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, c1, c2, b0, a0;
      int per, hi, lo;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(CN, v); chk("R1 count", v, 0);
      rd(RC, v); chk("R1 ctrl", v, 0);
      rd(RA, v); chk("R1 cmpa", v, 0);
      rd(PA, v); chk("R1 capa", v, 0);
      rd(PB, v); chk("R1 capb", v, 0);
      chk("R1 out", tmr_out, 0);
      chk("R1 irq", {irq_cmpa, irq_cmpb}, 0);

      // R3/R2 interval periods per tick source, table driven
      for (int i = 0; i < 4; i++) begin
         wr(RC, 16'd0);
         wr(RB, 16'(VTAB[i][0]));
         wr(RC, mk(1, 2'(VTAB[i][1]), 0, 1, 0, 0, 4'd0, 0, 0));
         measure(per);
         measure(per);
         chk($sformatf("R3 period vec%0d", i), per, VTAB[i][2]);
      end

      // R2 stopped counter holds zero, then counts one per tick
      wr(RC, 16'd0);
      repeat (20) @(negedge clk);
      rd(CN, v); chk("R2 stopped", v, 0);
      wr(RC, mk(1, 0, 0, 0, 0, 0, 4'd0, 0, 0));
      repeat (10) @(negedge clk);
      rd(CN, v); chk("R2 ten ticks", v, 10);

      // R13 external event counting
      wr(RC, 16'd0);
      wr(RC, mk(1, 3, 0, 0, 0, 0, 4'd0, 0, 0));
      for (int k = 0; k < 5; k++) begin pulse(3); repeat (3) @(negedge clk); end
      repeat (5) @(negedge clk);
      rd(CN, v); chk("R13 ext count", v, 5);

      // R4 strobe aligned with counter
      wr(RC, 16'd0);
      wr(RB, 16'd9);
      wr(RA, 16'd4);
      wr(RC, mk(1, 0, 0, 1, 0, 0, 4'd0, 0, 0));
      per = 0;
      while (irq_cmpa !== 1'b1 && per < 100) begin @(negedge clk); per++; end
      rd(CN, v); chk("R4 count at strobe", v, 4);
      @(negedge clk);
      chk("R4 one cycle", irq_cmpa, 0);

      // R5 double buffer
      wr(RC, 16'd0);
      wr(RB, 16'd99);
      wr(RA, 16'd10);
      wr(RC, mk(1, 0, 0, 1, 1, 0, 4'd0, 0, 0));
      repeat (20) @(negedge clk);
      wr(RA, 16'd50);
      rd(RA, v); chk("R5 held", v, 10);
      measure(per);
      repeat (2) @(negedge clk);
      rd(RA, v); chk("R5 shifted", v, 50);
      wr(RC, mk(1, 0, 0, 1, 0, 0, 4'd0, 0, 0));
      wr(RA, 16'd70);
      rd(RA, v); chk("R5 direct", v, 70);

      // R3 free-run wrap, compare A at zero
      wr(RC, 16'd0);
      wr(RA, 16'd0);
      wr(RC, mk(1, 0, 0, 0, 0, 0, 4'd0, 0, 0));
      repeat (65536) @(negedge clk);
      rd(CN, v); chk("R3 wrap count", v, 0);
      chk("R4 strobe on wrap", irq_cmpa, 1);

      // R6 pulse width
      wr(RC, 16'd0);
      wr(RC, mk(1, 0, 1, 0, 0, 0, 4'd0, 0, 0));
      repeat (5) @(negedge clk);
      pulse(7);
      repeat (6) @(negedge clk);
      rd(PA, c1); rd(PB, c2);
      chk("R6 width", 16'(c2 - c1), 7);

      // R7 time difference on rising edges
      wr(RC, 16'd0);
      wr(RC, mk(1, 0, 2, 0, 0, 0, 4'd0, 0, 0));
      repeat (3) @(negedge clk);
      rd(PB, b0);
      pulse(3);
      repeat (4) @(negedge clk);
      rd(PA, c1);
      repeat (18) @(negedge clk);
      pulse(3);
      repeat (4) @(negedge clk);
      rd(PA, c2);
      chk("R7 difference", 16'(c2 - c1), 25);
      rd(PB, v); chk("R7 capb kept", v, b0);

      // R8 capture B on compare A match
      wr(RC, 16'd0);
      wr(RB, 16'd199);
      wr(RA, 16'd37);
      wr(RC, mk(1, 0, 3, 1, 0, 0, 4'd0, 0, 0));
      pulse(3);
      per = 0;
      while (irq_cmpa !== 1'b1 && per < 500) begin @(negedge clk); per++; end
      repeat (2) @(negedge clk);
      rd(PB, v); chk("R8 capb match", v, 37);

      // R9 mode 00 ignores trigger
      wr(RC, mk(1, 0, 0, 0, 0, 0, 4'd0, 0, 0));
      repeat (3) @(negedge clk);
      rd(PA, a0); rd(PB, b0);
      pulse(4);
      repeat (6) @(negedge clk);
      rd(PA, v); chk("R9 capa kept", v, a0);
      rd(PB, v); chk("R9 capb kept", v, b0);

      // R10 software capture
      repeat (5) @(negedge clk);
      rd(CN, c1);
      wr(RC, mk(1, 0, 0, 0, 0, 1, 4'd0, 0, 0));
      rd(PA, v); chk("R10 sw capture", v, c1);
      rd(RC, v); chk("R10 cmd reads 0", v[7], 0);

      // R11 PPG from both compares
      wr(RC, 16'd0);
      wr(RA, 16'd3);
      wr(RB, 16'd9);
      wr(RC, mk(1, 0, 0, 1, 0, 0, 4'b0011, 1, 0));
      per = 0;
      while (tmr_out !== 1'b1 && per < 100) begin @(negedge clk); per++; end
      hi = 0;
      while (tmr_out === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
      lo = 0;
      while (tmr_out !== 1'b1 && lo < 100) begin @(negedge clk); lo++; end
      chk("R11 ppg high", hi, 6);
      chk("R11 ppg low", lo, 4);

      // R11 simultaneous events cancel
      wr(RC, 16'd0);
      wr(RA, 16'd5);
      wr(RB, 16'd5);
      wr(RC, mk(1, 0, 0, 1, 0, 0, 4'b0011, 1, 0));
      hi = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (tmr_out) hi++; end
      chk("R11 even events", hi, 0);

      // R11 one-shot by capture load inversion
      wr(RC, mk(1, 0, 2, 0, 0, 0, 4'b0100, 1, 0));
      pulse(3);
      repeat (6) @(negedge clk);
      chk("R11 capture invert on", tmr_out, 1);
      pulse(3);
      repeat (6) @(negedge clk);
      chk("R11 capture invert off", tmr_out, 0);

      // R12 forced level
      wr(RC, mk(0, 0, 0, 0, 0, 0, 4'd0, 1, 1));
      chk("R12 force high", tmr_out, 1);
      wr(RC, mk(0, 0, 0, 0, 0, 0, 4'd0, 1, 0));
      chk("R12 force low", tmr_out, 0);
      rd(RC, v); chk("R12 cmd reads 0", v[13:12], 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule